// File: doc/BRIEF.md
# Dual-Channel Receive Write Supervisor

This block supervises how a host processor delivers the per-frame receive payloads for a pair of voice channels into a codec. At each frame start it opens a valid write window and raises a write request. The request carries a first-request marker. Once a full payload has been delivered, the request continues without the marker. Once the second payload is complete, the request drops. Before each payload the host names the channel it is about to write. The block then routes every accepted byte with its channel and index to the payload store, which lies outside this block.

The window length is counted in millisecond ticks and depends on the frame mode: 9 ms for 10 ms frames and 18 ms for 20 ms frames. When the window closes, each channel's late-write error is updated from whether its payload arrived. A payload that repeats a channel already completed in the frame raises a duplicate-write error. Both kinds of error stay set until a later clean frame clears them. A downstream decoder uses the per-channel good strobe to choose between real data and concealment. The block also filters the enables for the channel pair. Once receive and transmit are both stopped, it refuses to restart them until a hold-off time has passed.

Top module: `rx_write_supervisor`

## Requirements
- R1: `wr_req` rises in the cycle after `frame_start`, with `wr_req_first`=1. After the first completed payload, `wr_req` stays 1 with `wr_req_first`=0. After the second completed payload, or at window close, `wr_req` is 0. `wr_req_first` is never 1 while `wr_req` is 0.
- R2: A `chan_note_wr` pulse during an open window selects the channel `chan_note` (0 = channel 0, 1 = channel 1) and restarts the byte index. Each following `byte_wr` is accepted (`byte_take`=1) with `byte_chan` equal to that channel and `byte_index` counting 0 to BYTES-1.
- R3: Some bytes are dropped (`byte_take`=0). This covers a byte with no channel named in the current window, a byte after the selected payload is already complete, a byte while the window is closed, and a byte in the same cycle as `chan_note_wr`.
- R4: The window opens on `frame_start` and closes on the SHORT_MS-th tick (`long_frame`=0) or the LONG_MS-th tick (`long_frame`=1). The mode is sampled at `frame_start`.
- R5: In the cycle after the last byte of a payload, `frame_good` pulses for one cycle on bit 0 (channel 0) or bit 1 (channel 1). It does not pulse when the payload repeats a channel already completed in the frame.
- R6: At window close, `rx_late_err[c]` is cleared if channel c completed a payload in that frame. Otherwise it is set if `rx_active` is 1. At no other time does it change.
- R7: Naming a channel that already completed in the frame sets `dup_err` in the next cycle. At window close, `dup_err` is cleared if that frame saw no duplicate.
- R8: While `rx_active` is 0, requests are still issued, but a missing payload sets no late error.
- R9: `rx_active`/`tx_active` follow their requests one cycle later. Once both requests have dropped from an active state, both outputs are held at 0 until HOLD_MS+1 further ticks have been counted.
- R10: After reset, every output register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| long_frame | input | 1 | 0 = 10 ms frames, 1 = 20 ms frames |
| rx_enable_req | input | 1 | Host request to enable the receive pair |
| tx_enable_req | input | 1 | Host request to enable the transmit pair |
| chan_note_wr | input | 1 | Host strobe naming the next payload's channel |
| chan_note | input | 1 | Channel named by the strobe |
| byte_wr | input | 1 | Host payload byte strobe |
| rx_active | output | 1 | Filtered receive enable |
| tx_active | output | 1 | Filtered transmit enable |
| wr_req | output | 1 | Receive write request |
| wr_req_first | output | 1 | Marks the first request of the frame |
| byte_take | output | 1 | Current byte is accepted |
| byte_chan | output | 1 | Channel of the accepted byte |
| byte_index | output | $clog2(BYTES) | Index of the accepted byte in its payload |
| frame_good | output | 2 | Per-channel payload-complete strobe |
| rx_late_err | output | 2 | Per-channel sticky late-write error |
| dup_err | output | 1 | Sticky duplicate-write error |

## Verification
The bench keeps the full 80-byte payload and the 9 ms and 18 ms windows. This lets it check that each window edge lands on the exact closing tick, and that the good strobe lands on the exact last byte. HOLD_MS is reduced to 4, so the restart guard can be seen both to block and then to release within a short run. Directed frames walk through several paths: the set and clear of the late and duplicate errors, the drop of stray bytes, and operation with the receive pair disabled.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } rxw_phase_e;

endpackage

// File: rtl/rxw_window.sv
module rxw_window #(
    parameter int SHORT_MS = 9,
    parameter int LONG_MS  = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic ms_tick,
    input  logic long_frame,
    output logic win_open,
    output logic win_close
);
    localparam int CNT_W = $clog2(LONG_MS + 1);

    typedef struct packed {
        logic             open;
        logic             long_m;
        logic [CNT_W-1:0] cnt;
    } win_s;

    win_s             win_q, win_d;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        limit     = win_q.long_m ? CNT_W'(LONG_MS) : CNT_W'(SHORT_MS);
        cnt_inc   = win_q.cnt + 1'b1;
        win_d     = win_q;
        win_close = 1'b0;
        if (frame_start) begin
            // A new frame also ends a window still open from the last one.
            win_close    = win_q.open;
            win_d.open   = 1'b1;
            win_d.long_m = long_frame;
            win_d.cnt    = '0;
        end else if (win_q.open && ms_tick) begin
            win_d.cnt = cnt_inc;
            if (cnt_inc >= limit) begin
                win_d.open = 1'b0;
                win_close  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win_open = win_q.open;

endmodule

// File: rtl/rxw_payload.sv
module rxw_payload
    import rxw_pkg::*;
#(
    parameter int BYTES = 80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     win_open,
    input  logic                     win_close,
    input  logic                     note_wr,
    input  logic                     note_ch,
    input  logic                     byte_wr,
    output logic                     take,
    output logic                     take_ch,
    output logic [$clog2(BYTES)-1:0] take_idx,
    output logic                     req,
    output logic                     req_first,
    output logic [1:0]               done,
    output logic                     dup_hit,
    output logic [1:0]               good
);
    localparam int                 IDX_W = $clog2(BYTES);
    localparam logic [IDX_W-1:0]   LAST  = IDX_W'(BYTES - 1);

    typedef struct packed {
        rxw_phase_e       phase;
        logic             sel_ok;
        logic             sel_ch;
        logic [IDX_W-1:0] idx;
        logic             dup_pay;
        logic [1:0]       done;
        logic [1:0]       good;
    } pay_s;

    pay_s pay_q, pay_d;
    logic live;

    always_comb begin
        live    = win_open && !win_close && !frame_start;
        pay_d   = pay_q;
        pay_d.good = '0;
        take    = 1'b0;
        dup_hit = 1'b0;
        if (frame_start) begin
            pay_d.phase   = PH_FIRST;
            pay_d.sel_ok  = 1'b0;
            pay_d.idx     = '0;
            pay_d.done    = '0;
            pay_d.dup_pay = 1'b0;
        end else if (win_close) begin
            pay_d.phase  = PH_IDLE;
            pay_d.sel_ok = 1'b0;
        end else if (live && note_wr) begin
            pay_d.sel_ok  = 1'b1;
            pay_d.sel_ch  = note_ch;
            pay_d.idx     = '0;
            pay_d.dup_pay = pay_q.done[note_ch];
            dup_hit       = pay_q.done[note_ch];
        end else if (live && byte_wr && pay_q.sel_ok) begin
            take      = 1'b1;
            pay_d.idx = pay_q.idx + 1'b1;
            if (pay_q.idx == LAST) begin
                pay_d.sel_ok = 1'b0;
                pay_d.idx    = '0;
                if (!pay_q.dup_pay) begin
                    pay_d.done[pay_q.sel_ch] = 1'b1;
                    pay_d.good[pay_q.sel_ch] = 1'b1;
                end
                case (pay_q.phase)
                    PH_FIRST:  pay_d.phase = PH_SECOND;
                    PH_SECOND: pay_d.phase = PH_IDLE;
                    default:   pay_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pay_q <= '{phase: PH_IDLE, default: '0};
        else        pay_q <= pay_d;
    end

    assign take_ch   = pay_q.sel_ch;
    assign take_idx  = pay_q.idx;
    assign req       = (pay_q.phase != PH_IDLE);
    assign req_first = (pay_q.phase == PH_FIRST);
    assign done      = pay_q.done;
    assign good      = pay_q.good;

endmodule

// File: rtl/rxw_errors.sv
module rxw_errors #(
    parameter int CHANS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_close,
    input  logic [CHANS-1:0] done,
    input  logic             dup_hit,
    input  logic             rx_on,
    output logic [CHANS-1:0] late_err,
    output logic             dup_err
);
    typedef struct packed {
        logic [CHANS-1:0] late;
        logic             dup;
        logic             dup_seen;
    } err_s;

    err_s err_q, err_d;

    always_comb begin
        err_d = err_q;
        if (dup_hit) begin
            err_d.dup      = 1'b1;
            err_d.dup_seen = 1'b1;
        end
        if (win_close) begin
            for (int c = 0; c < CHANS; c++) begin
                if (done[c])    err_d.late[c] = 1'b0;
                else if (rx_on) err_d.late[c] = 1'b1;
            end
            err_d.dup      = err_q.dup_seen;
            err_d.dup_seen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign late_err = err_q.late;
    assign dup_err  = err_q.dup;

endmodule

// File: rtl/rxw_guard.sv
module rxw_guard #(
    parameter int HOLD_MS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rx_req,
    input  logic tx_req,
    output logic rx_on,
    output logic tx_on
);
    localparam int              HOLD_W = $clog2(HOLD_MS + 2);
    localparam logic [HOLD_W-1:0] LOAD = HOLD_W'(HOLD_MS + 1);

    typedef struct packed {
        logic              rx;
        logic              tx;
        logic [HOLD_W-1:0] hold;
    } grd_s;

    grd_s grd_q, grd_d;

    always_comb begin
        grd_d = grd_q;
        if (grd_q.hold != '0) begin
            grd_d.rx = 1'b0;
            grd_d.tx = 1'b0;
            if (ms_tick) grd_d.hold = grd_q.hold - 1'b1;
        end else if ((grd_q.rx || grd_q.tx) && !rx_req && !tx_req) begin
            // One extra tick covers a tick that lands right after the stop.
            grd_d.hold = LOAD;
            grd_d.rx   = 1'b0;
            grd_d.tx   = 1'b0;
        end else begin
            grd_d.rx = rx_req;
            grd_d.tx = tx_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) grd_q <= '0;
        else        grd_q <= grd_d;
    end

    assign rx_on = grd_q.rx;
    assign tx_on = grd_q.tx;

endmodule

// File: rtl/rx_write_supervisor.sv
module rx_write_supervisor #(
    parameter int BYTES    = 80,
    parameter int SHORT_MS = 9,
    parameter int LONG_MS  = 18,
    parameter int HOLD_MS  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     ms_tick,
    input  logic                     long_frame,
    input  logic                     rx_enable_req,
    input  logic                     tx_enable_req,
    input  logic                     chan_note_wr,
    input  logic                     chan_note,
    input  logic                     byte_wr,
    output logic                     rx_active,
    output logic                     tx_active,
    output logic                     wr_req,
    output logic                     wr_req_first,
    output logic                     byte_take,
    output logic                     byte_chan,
    output logic [$clog2(BYTES)-1:0] byte_index,
    output logic [1:0]               frame_good,
    output logic [1:0]               rx_late_err,
    output logic                     dup_err
);
    logic       win_open;
    logic       win_close;
    logic [1:0] done;
    logic       dup_hit;

    rxw_guard #(.HOLD_MS(HOLD_MS)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .ms_tick(ms_tick),
        .rx_req (rx_enable_req),
        .tx_req (tx_enable_req),
        .rx_on  (rx_active),
        .tx_on  (tx_active)
    );

    rxw_window #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .ms_tick    (ms_tick),
        .long_frame (long_frame),
        .win_open   (win_open),
        .win_close  (win_close)
    );

    rxw_payload #(.BYTES(BYTES)) u_pay (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .win_open   (win_open),
        .win_close  (win_close),
        .note_wr    (chan_note_wr),
        .note_ch    (chan_note),
        .byte_wr    (byte_wr),
        .take       (byte_take),
        .take_ch    (byte_chan),
        .take_idx   (byte_index),
        .req        (wr_req),
        .req_first  (wr_req_first),
        .done       (done),
        .dup_hit    (dup_hit),
        .good       (frame_good)
    );

    rxw_errors #(.CHANS(2)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_close(win_close),
        .done     (done),
        .dup_hit  (dup_hit),
        .rx_on    (rx_active),
        .late_err (rx_late_err),
        .dup_err  (dup_err)
    );

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int BYTES = 80
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     chan_note_wr,
    input logic                     byte_wr,
    input logic                     byte_take,
    input logic [$clog2(BYTES)-1:0] byte_index,
    input logic [1:0]               frame_good,
    input logic                     wr_req,
    input logic                     wr_req_first,
    input logic [1:0]               rx_late_err,
    input logic                     dup_err,
    input logic                     win_close,
    input logic                     rx_active,
    input logic                     tx_active
);
    localparam logic [$clog2(BYTES)-1:0] LAST = $clog2(BYTES)'(BYTES - 1);

    p_first_in_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_first |-> wr_req);

    p_index_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> (byte_index <= LAST));

    p_take_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> (byte_wr && !chan_note_wr));

    p_good_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|frame_good) |-> $past(byte_take && (byte_index == LAST)));

    p_good_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(frame_good));

    p_late_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !win_close |=> $stable(rx_late_err));

    p_dup_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dup_err) |-> $past(chan_note_wr));

    p_guard_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_active || tx_active) && !rx_active && !tx_active)
        |=> (!rx_active && !tx_active));

endmodule

bind rx_write_supervisor rxw_checker #(.BYTES(BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_note_wr(chan_note_wr),
    .byte_wr     (byte_wr),
    .byte_take   (byte_take),
    .byte_index  (byte_index),
    .frame_good  (frame_good),
    .wr_req      (wr_req),
    .wr_req_first(wr_req_first),
    .rx_late_err (rx_late_err),
    .dup_err     (dup_err),
    .win_close   (win_close),
    .rx_active   (rx_active),
    .tx_active   (tx_active)
);

// File: tb/rx_write_supervisor_test.sv
`timescale 1ns/100ps
module rx_write_supervisor_test;
    localparam int BYTES = 80;
    localparam int SHORT = 9;
    localparam int LONG  = 18;
    localparam int HOLD  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, ms_tick = 1'b0, long_frame = 1'b0;
    logic rx_enable_req = 1'b0, tx_enable_req = 1'b0;
    logic chan_note_wr = 1'b0, chan_note = 1'b0, byte_wr = 1'b0;
    logic rx_active, tx_active, wr_req, wr_req_first, byte_take, byte_chan, dup_err;
    logic [$clog2(BYTES)-1:0] byte_index;
    logic [1:0] frame_good, rx_late_err;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_write_supervisor #(.BYTES(BYTES), .SHORT_MS(SHORT), .LONG_MS(LONG), .HOLD_MS(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ms_tick(ms_tick),
        .long_frame(long_frame), .rx_enable_req(rx_enable_req), .tx_enable_req(tx_enable_req),
        .chan_note_wr(chan_note_wr), .chan_note(chan_note), .byte_wr(byte_wr),
        .rx_active(rx_active), .tx_active(tx_active), .wr_req(wr_req),
        .wr_req_first(wr_req_first), .byte_take(byte_take), .byte_chan(byte_chan),
        .byte_index(byte_index), .frame_good(frame_good), .rx_late_err(rx_late_err),
        .dup_err(dup_err)
    );

    task automatic check(input string tag, input int actual, input int expected);
        nchk++;
        if (actual != expected) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic start_frame(input logic lng);
        @(negedge clk) begin frame_start = 1'b1; long_frame = lng; end
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic name_chan(input logic ch);
        @(negedge clk) begin chan_note_wr = 1'b1; chan_note = ch; end
        @(negedge clk) chan_note_wr = 1'b0;
    endtask

    // Writes n bytes back to back; counts routing mismatches and checks once.
    task automatic put_bytes(input int n, input logic ch, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) byte_wr = 1'b1;
            #1;
            if (!byte_take || byte_chan != ch || int'(byte_index) != i) bad++;
        end
        @(negedge clk) byte_wr = 1'b0;
        check(tag, bad, 0);
    endtask

    task automatic one_byte_dropped(input string tag);
        @(negedge clk) byte_wr = 1'b1;
        #1 check(tag, int'(byte_take), 0);
        @(negedge clk) byte_wr = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 wr_req", int'(wr_req), 0);
        check("R10 wr_req_first", int'(wr_req_first), 0);
        check("R10 late_err", int'(rx_late_err), 0);
        check("R10 dup_err", int'(dup_err), 0);
        check("R10 frame_good", int'(frame_good), 0);
        check("R10 active", int'({rx_active, tx_active}), 0);
        rx_enable_req = 1'b1; tx_enable_req = 1'b1;
        @(negedge clk);
        check("R9 follow enables", int'({rx_active, tx_active}), 3);
    endtask

    task automatic t_normal;
        start_frame(1'b0);
        check("R1 first request", int'({wr_req, wr_req_first}), 3);
        name_chan(1'b0);
        put_bytes(BYTES, 1'b0, "R2 ch0 routing");
        check("R5 good ch0", int'(frame_good), 1);
        check("R1 second request", int'({wr_req, wr_req_first}), 2);
        @(negedge clk);
        check("R5 good one cycle", int'(frame_good), 0);
        name_chan(1'b1);
        put_bytes(BYTES, 1'b1, "R2 ch1 routing");
        check("R5 good ch1", int'(frame_good), 2);
        check("R1 request done", int'(wr_req), 0);
        ticks(SHORT);
        check("R6 clean frame", int'(rx_late_err), 0);
    endtask

    task automatic t_window;
        start_frame(1'b0);
        name_chan(1'b0);
        put_bytes(BYTES, 1'b0, "R2 ch0 only");
        ticks(SHORT - 1);
        check("R4 short still open", int'(wr_req), 1);
        ticks(1);
        check("R4 short closed", int'(wr_req), 0);
        check("R6 ch1 late", int'(rx_late_err), 2);
        start_frame(1'b1);
        ticks(LONG - 1);
        check("R4 long still open", int'(wr_req), 1);
        check("R6 held mid frame", int'(rx_late_err), 2);
        ticks(1);
        check("R4 long closed", int'(wr_req), 0);
        check("R6 both late", int'(rx_late_err), 3);
        start_frame(1'b0);
        name_chan(1'b1);
        put_bytes(BYTES, 1'b1, "R2 ch1 first");
        name_chan(1'b0);
        put_bytes(BYTES, 1'b0, "R2 ch0 second");
        ticks(SHORT);
        check("R6 cleared", int'(rx_late_err), 0);
    endtask

    task automatic t_drop;
        start_frame(1'b0);
        one_byte_dropped("R3 no channel named");
        name_chan(1'b0);
        put_bytes(BYTES, 1'b0, "R2 after stray");
        one_byte_dropped("R3 past payload end");
        ticks(SHORT);
        check("R6 ch1 missing", int'(rx_late_err), 2);
        name_chan(1'b1);
        one_byte_dropped("R3 window closed");
    endtask

    task automatic t_dup;
        start_frame(1'b0);
        name_chan(1'b0);
        put_bytes(BYTES, 1'b0, "R2 ch0");
        name_chan(1'b0);
        check("R7 dup set", int'(dup_err), 1);
        put_bytes(BYTES, 1'b0, "R2 repeat ch0");
        check("R5 no good on repeat", int'(frame_good), 0);
        check("R1 request ends", int'(wr_req), 0);
        ticks(SHORT);
        check("R7 dup held", int'(dup_err), 1);
        check("R6 ch1 late", int'(rx_late_err), 2);
        start_frame(1'b0);
        name_chan(1'b0);
        put_bytes(BYTES, 1'b0, "R2 clean ch0");
        name_chan(1'b1);
        put_bytes(BYTES, 1'b1, "R2 clean ch1");
        check("R7 dup held until close", int'(dup_err), 1);
        ticks(SHORT);
        check("R7 dup cleared", int'(dup_err), 0);
        check("R6 cleared", int'(rx_late_err), 0);
    endtask

    task automatic t_disabled;
        @(negedge clk) rx_enable_req = 1'b0;
        @(negedge clk);
        check("R9 rx off tx on", int'({rx_active, tx_active}), 1);
        start_frame(1'b0);
        check("R8 request still issued", int'(wr_req), 1);
        ticks(SHORT);
        check("R8 no late error", int'(rx_late_err), 0);
        @(negedge clk) rx_enable_req = 1'b1;
        @(negedge clk);
        check("R9 rx back on", int'(rx_active), 1);
    endtask

    task automatic t_guard;
        @(negedge clk) begin rx_enable_req = 1'b0; tx_enable_req = 1'b0; end
        @(negedge clk) begin rx_enable_req = 1'b1; tx_enable_req = 1'b1; end
        check("R9 stopped", int'({rx_active, tx_active}), 0);
        repeat (2) @(negedge clk);
        check("R9 restart rejected", int'({rx_active, tx_active}), 0);
        ticks(HOLD);
        check("R9 still rejected", int'({rx_active, tx_active}), 0);
        ticks(1);
        @(negedge clk);
        check("R9 restart allowed", int'({rx_active, tx_active}), 3);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_window();
        t_drop();
        t_dup();
        t_disabled();
        t_guard();
        finished = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule